// File: doc/BRIEF.md
# Split Instruction/Data Translation Lookaside Buffer

This block translates virtual page numbers to physical page numbers for a core whose caches are virtually indexed but physically tagged. It holds two fully associative arrays, one serving instruction fetches and one serving data accesses. Each has its own lookup port, so both ports can search in the same cycle without contending. A request presented in the address-generation cycle is resolved by the next clock edge. The registered hit flag, physical page number and attribute bits are then valid throughout the following stage, where the cache controller compares them against its physical tags.

Software maintains the arrays through a single allocation index register. The low six bits of a 16-bit slot register address all 64 entries: bit 5 clear selects the instruction array and bit 5 set selects the data array, with bits 4:0 choosing the entry within that array. An entry write loads valid, tag, physical page and attributes into the entry the current index selects. A combinational read-back port returns the same fields for that entry. Pages are 4 KB, so tags and physical pages are 20 bits. The attribute field is 3 bits: bit 2 = supervisor-only, bit 1 = write-protect, bit 0 = cacheable.

Top module: `split_tlb`

## Requirements
- R1: After reset every entry is invalid, the slot register reads zero, and both lookup ports show hit=0 and miss=0 with zero page and attribute outputs.
- R2: A slot register write keeps bits 5:0 of the written value, and bits 15:6 always read as zero.
- R3: An entry write loads the entry at slot index bits 4:0 of the instruction array when bit 5 is 0, or of the data array when bit 5 is 1. The read-back port returns that entry's valid, tag, page and attributes.
- R4: An instruction request whose page matches a valid instruction entry gives hit=1, miss=0, and that entry's page and attributes on the edge after the request.
- R5: A data request behaves the same way against the data array only. An entry in one array never produces a hit on the other port.
- R6: A request that matches no valid entry in its array gives miss=1, hit=0, and a page and attributes of zero.
- R7: An entry written with valid=0 never matches.
- R8: When several valid entries of one array match, the result comes from the lowest-numbered one.
- R9: The two ports resolve independently when both request in the same cycle.
- R10: In a cycle after one with no request on a port, that port shows hit=0, miss=0, page 0 and attributes 0.
- R11: An entry write in the same cycle as a slot register write uses the old index. A lookup in the cycle of an entry write sees the array contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ilk_req | input | 1 | Instruction lookup request |
| ilk_vpn | input | 20 | Instruction virtual page number |
| ilk_hit | output | 1 | Instruction lookup hit (registered) |
| ilk_miss | output | 1 | Instruction lookup miss (registered) |
| ilk_ppn | output | 20 | Instruction physical page, zero unless hit |
| ilk_attr | output | 3 | Instruction attributes {supervisor, write-protect, cacheable} |
| dlk_req | input | 1 | Data lookup request |
| dlk_vpn | input | 20 | Data virtual page number |
| dlk_hit | output | 1 | Data lookup hit (registered) |
| dlk_miss | output | 1 | Data lookup miss (registered) |
| dlk_ppn | output | 20 | Data physical page, zero unless hit |
| dlk_attr | output | 3 | Data attributes |
| slot_we | input | 1 | Slot register write strobe |
| slot_wdata | input | 16 | Slot register write value |
| slot_rdata | output | 16 | Slot register value, bits 15:6 zero |
| ent_we | input | 1 | Entry write strobe |
| ent_wvalid | input | 1 | Valid bit to write |
| ent_wtag | input | 20 | Virtual page tag to write |
| ent_wppn | input | 20 | Physical page to write |
| ent_wattr | input | 3 | Attributes to write |
| ent_rvalid | output | 1 | Read-back valid of the selected entry |
| ent_rtag | output | 20 | Read-back tag |
| ent_rppn | output | 20 | Read-back physical page |
| ent_rattr | output | 3 | Read-back attributes |

## Verification
The bench places the same tag in both arrays and checks that each port returns only its own array's page. A design that ignored slot bit 5 would answer one port from the wrong half. It loads duplicate tags at two indices and then invalidates the lower one. A wrong priority order or a stale valid bit would return the other page. It writes the slot register and an entry in the same cycle, and a design that applied the new index first would place the entry in the wrong slot. Random traffic over a small tag pool keeps hits, misses and lookups that coincide with writes frequent. This exposes a lookup that sees a write too early, or a miss that leaks a nonzero page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 20;
  localparam int PPN_W  = 20;
  localparam int ATTR_W = 3;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  tag;
    logic [PPN_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_prio_enc.sv
// Lowest-index-first priority encoder over a match vector.
module tlb_prio_enc #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/tlb_half.sv
// One fully associative array with its own lookup port and a write/read slot.
module tlb_half
  import tlb_pkg::*;
#(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  tlb_entry_t        wr_entry,
  input  logic [IW-1:0]     rd_idx,
  output tlb_entry_t        rd_entry,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [ATTR_W-1:0] lk_attr
);
  logic              valid_q [N];
  logic [VPN_W-1:0]  tag_q   [N];
  logic [PPN_W-1:0]  ppn_q   [N];
  logic [ATTR_W-1:0] attr_q  [N];

  logic [N-1:0]      match;
  logic              found;
  logic [IW-1:0]     win;

  logic              hit_d, miss_d;
  logic [PPN_W-1:0]  ppn_d;
  logic [ATTR_W-1:0] attr_d;
  logic              hit_q, miss_q;
  logic [PPN_W-1:0]  ppn_q_o;
  logic [ATTR_W-1:0] attr_q_o;

  // Valid bits carry reset; payload does not.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) valid_q[k] <= 1'b0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_entry.valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_entry.tag;
      ppn_q[wr_idx]  <= wr_entry.ppn;
      attr_q[wr_idx] <= wr_entry.attr;
    end
  end

  // Parallel compare against every entry.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  tlb_prio_enc #(.N(N)) u_enc (
    .req   (match),
    .found (found),
    .idx   (win)
  );

  always_comb begin
    hit_d  = lk_req && found;
    miss_d = lk_req && !found;
    ppn_d  = hit_d ? ppn_q[win]  : '0;
    attr_d = hit_d ? attr_q[win] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      miss_q   <= 1'b0;
      ppn_q_o  <= '0;
      attr_q_o <= '0;
    end else begin
      hit_q    <= hit_d;
      miss_q   <= miss_d;
      ppn_q_o  <= ppn_d;
      attr_q_o <= attr_d;
    end
  end

  assign lk_hit  = hit_q;
  assign lk_miss = miss_q;
  assign lk_ppn  = ppn_q_o;
  assign lk_attr = attr_q_o;

  assign rd_entry.valid = valid_q[rd_idx];
  assign rd_entry.tag   = tag_q[rd_idx];
  assign rd_entry.ppn   = ppn_q[rd_idx];
  assign rd_entry.attr  = attr_q[rd_idx];
endmodule

// File: rtl/split_tlb.sv
// Split instruction/data translation buffer with a shared slot index.
// rst_n is expected to be deasserted synchronously to clk upstream.
module split_tlb
  import tlb_pkg::*;
#(
  parameter int HALF_ENTRIES = 32,
  parameter int SLOT_W       = 16,
  localparam int IDX_W  = $clog2(2 * HALF_ENTRIES),
  localparam int HIDX_W = $clog2(HALF_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ilk_req,
  input  logic [VPN_W-1:0]  ilk_vpn,
  output logic              ilk_hit,
  output logic              ilk_miss,
  output logic [PPN_W-1:0]  ilk_ppn,
  output logic [ATTR_W-1:0] ilk_attr,
  input  logic              dlk_req,
  input  logic [VPN_W-1:0]  dlk_vpn,
  output logic              dlk_hit,
  output logic              dlk_miss,
  output logic [PPN_W-1:0]  dlk_ppn,
  output logic [ATTR_W-1:0] dlk_attr,
  input  logic              slot_we,
  input  logic [SLOT_W-1:0] slot_wdata,
  output logic [SLOT_W-1:0] slot_rdata,
  input  logic              ent_we,
  input  logic              ent_wvalid,
  input  logic [VPN_W-1:0]  ent_wtag,
  input  logic [PPN_W-1:0]  ent_wppn,
  input  logic [ATTR_W-1:0] ent_wattr,
  output logic              ent_rvalid,
  output logic [VPN_W-1:0]  ent_rtag,
  output logic [PPN_W-1:0]  ent_rppn,
  output logic [ATTR_W-1:0] ent_rattr
);
  logic [IDX_W-1:0]  slot_q, slot_d;
  logic              sel_data;
  logic [HIDX_W-1:0] sub_idx;
  tlb_entry_t        wr_entry, rd_i, rd_d, rd_sel;

  always_comb begin
    slot_d = slot_q;
    if (slot_we) slot_d = slot_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot_rdata = {{(SLOT_W-IDX_W){1'b0}}, slot_q};
  assign sel_data   = slot_q[IDX_W-1];
  assign sub_idx    = slot_q[HIDX_W-1:0];

  assign wr_entry.valid = ent_wvalid;
  assign wr_entry.tag   = ent_wtag;
  assign wr_entry.ppn   = ent_wppn;
  assign wr_entry.attr  = ent_wattr;

  tlb_half #(.N(HALF_ENTRIES)) u_itlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ent_we && !sel_data),
    .wr_idx   (sub_idx),
    .wr_entry (wr_entry),
    .rd_idx   (sub_idx),
    .rd_entry (rd_i),
    .lk_req   (ilk_req),
    .lk_vpn   (ilk_vpn),
    .lk_hit   (ilk_hit),
    .lk_miss  (ilk_miss),
    .lk_ppn   (ilk_ppn),
    .lk_attr  (ilk_attr)
  );

  tlb_half #(.N(HALF_ENTRIES)) u_dtlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ent_we && sel_data),
    .wr_idx   (sub_idx),
    .wr_entry (wr_entry),
    .rd_idx   (sub_idx),
    .rd_entry (rd_d),
    .lk_req   (dlk_req),
    .lk_vpn   (dlk_vpn),
    .lk_hit   (dlk_hit),
    .lk_miss  (dlk_miss),
    .lk_ppn   (dlk_ppn),
    .lk_attr  (dlk_attr)
  );

  assign rd_sel     = sel_data ? rd_d : rd_i;
  assign ent_rvalid = rd_sel.valid;
  assign ent_rtag   = rd_sel.tag;
  assign ent_rppn   = rd_sel.ppn;
  assign ent_rattr  = rd_sel.attr;
endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk #(
  parameter int IDX_W  = 6,
  parameter int SLOT_W = 16,
  parameter int PPN_W  = 20,
  parameter int ATTR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ilk_req,
  input logic              ilk_hit,
  input logic              ilk_miss,
  input logic [PPN_W-1:0]  ilk_ppn,
  input logic [ATTR_W-1:0] ilk_attr,
  input logic              dlk_req,
  input logic              dlk_hit,
  input logic              dlk_miss,
  input logic [PPN_W-1:0]  dlk_ppn,
  input logic [ATTR_W-1:0] dlk_attr,
  input logic              slot_we,
  input logic [SLOT_W-1:0] slot_wdata,
  input logic [SLOT_W-1:0] slot_rdata
);
  p_imiss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ilk_miss |-> (!ilk_hit && ilk_ppn == '0 && ilk_attr == '0));
  p_dmiss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dlk_miss |-> (!dlk_hit && dlk_ppn == '0 && dlk_attr == '0));
  p_ireq_resolves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ilk_req |=> (ilk_hit || ilk_miss));
  p_dreq_resolves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dlk_req |=> (dlk_hit || dlk_miss));
  p_iidle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ilk_req |=> (!ilk_hit && !ilk_miss && ilk_ppn == '0));
  p_didle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dlk_req |=> (!dlk_hit && !dlk_miss && dlk_ppn == '0));
  p_slot_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_we |=> (slot_rdata == {{(SLOT_W-IDX_W){1'b0}}, $past(slot_wdata[IDX_W-1:0])}));
  p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_we |=> $stable(slot_rdata));
endmodule

bind split_tlb split_tlb_chk #(
  .IDX_W(IDX_W), .SLOT_W(SLOT_W), .PPN_W(tlb_pkg::PPN_W), .ATTR_W(tlb_pkg::ATTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ilk_req(ilk_req), .ilk_hit(ilk_hit), .ilk_miss(ilk_miss), .ilk_ppn(ilk_ppn), .ilk_attr(ilk_attr),
  .dlk_req(dlk_req), .dlk_hit(dlk_hit), .dlk_miss(dlk_miss), .dlk_ppn(dlk_ppn), .dlk_attr(dlk_attr),
  .slot_we(slot_we), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata)
);

// File: tb/sim_split_tlb.sv
module sim_split_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ilk_req = 0, dlk_req = 0;
  logic [19:0] ilk_vpn = 0, dlk_vpn = 0;
  logic        ilk_hit, ilk_miss, dlk_hit, dlk_miss;
  logic [19:0] ilk_ppn, dlk_ppn;
  logic [2:0]  ilk_attr, dlk_attr;
  logic        slot_we = 0;
  logic [15:0] slot_wdata = 0;
  logic [15:0] slot_rdata;
  logic        ent_we = 0, ent_wvalid = 0;
  logic [19:0] ent_wtag = 0, ent_wppn = 0;
  logic [2:0]  ent_wattr = 0;
  logic        ent_rvalid;
  logic [19:0] ent_rtag, ent_rppn;
  logic [2:0]  ent_rattr;

  int checks = 0;
  int errors = 0;

  // Reference model
  logic        m_v    [2*HALF];
  logic [19:0] m_tag  [2*HALF];
  logic [19:0] m_ppn  [2*HALF];
  logic [2:0]  m_attr [2*HALF];
  logic [5:0]  m_slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_tlb u0 (
    .clk(clk), .rst_n(rst_n),
    .ilk_req(ilk_req), .ilk_vpn(ilk_vpn), .ilk_hit(ilk_hit), .ilk_miss(ilk_miss),
    .ilk_ppn(ilk_ppn), .ilk_attr(ilk_attr),
    .dlk_req(dlk_req), .dlk_vpn(dlk_vpn), .dlk_hit(dlk_hit), .dlk_miss(dlk_miss),
    .dlk_ppn(dlk_ppn), .dlk_attr(dlk_attr),
    .slot_we(slot_we), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata),
    .ent_we(ent_we), .ent_wvalid(ent_wvalid), .ent_wtag(ent_wtag), .ent_wppn(ent_wppn),
    .ent_wattr(ent_wattr),
    .ent_rvalid(ent_rvalid), .ent_rtag(ent_rtag), .ent_rppn(ent_rppn), .ent_rattr(ent_rattr)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Lowest matching valid entry in one half, or -1.
  function automatic int find(input int base, input logic [19:0] vpn);
    for (int e = 0; e < HALF; e++)
      if (m_v[base+e] && m_tag[base+e] == vpn) return e;
    return -1;
  endfunction

  // One cycle: inputs already driven at negedge; compute expectation, clock, check.
  task automatic step(input string tag);
    int ie, de;
    logic        ei_hit, ei_miss, ed_hit, ed_miss;
    logic [19:0] ei_ppn, ed_ppn;
    logic [2:0]  ei_attr, ed_attr;
    ie = find(0, ilk_vpn);
    de = find(HALF, dlk_vpn);
    ei_hit  = ilk_req && ie >= 0;  ei_miss = ilk_req && ie < 0;
    ed_hit  = dlk_req && de >= 0;  ed_miss = dlk_req && de < 0;
    ei_ppn  = ei_hit ? m_ppn[ie]       : 20'h0;
    ei_attr = ei_hit ? m_attr[ie]      : 3'h0;
    ed_ppn  = ed_hit ? m_ppn[HALF+de]  : 20'h0;
    ed_attr = ed_hit ? m_attr[HALF+de] : 3'h0;
    @(posedge clk);
    if (ent_we) begin
      m_v[m_slot] = ent_wvalid; m_tag[m_slot] = ent_wtag;
      m_ppn[m_slot] = ent_wppn; m_attr[m_slot] = ent_wattr;
    end
    if (slot_we) m_slot = slot_wdata[5:0];
    @(negedge clk);
    chk(tag, "ihit",  ilk_hit,  ei_hit);
    chk(tag, "imiss", ilk_miss, ei_miss);
    chk(tag, "ippn",  ilk_ppn,  ei_ppn);
    chk(tag, "iattr", ilk_attr, ei_attr);
    chk(tag, "dhit",  dlk_hit,  ed_hit);
    chk(tag, "dmiss", dlk_miss, ed_miss);
    chk(tag, "dppn",  dlk_ppn,  ed_ppn);
    chk(tag, "dattr", dlk_attr, ed_attr);
    chk(tag, "slot",  slot_rdata, {10'h0, m_slot});
    chk(tag, "rvalid", ent_rvalid, m_v[m_slot]);
    if (m_v[m_slot]) begin
      chk(tag, "rtag",  ent_rtag,  m_tag[m_slot]);
      chk(tag, "rppn",  ent_rppn,  m_ppn[m_slot]);
      chk(tag, "rattr", ent_rattr, m_attr[m_slot]);
    end
    ilk_req = 0; dlk_req = 0; slot_we = 0; ent_we = 0;
  endtask

  task automatic set_slot(input logic [15:0] v, input string tag);
    slot_we = 1; slot_wdata = v; step(tag);
  endtask

  task automatic put(input logic [5:0] idx, input logic v, input logic [19:0] t,
                     input logic [19:0] p, input logic [2:0] a, input string tag);
    set_slot({10'h3A5, idx}, tag);  // upper bits deliberately nonzero (R2)
    ent_we = 1; ent_wvalid = v; ent_wtag = t; ent_wppn = p; ent_wattr = a;
    step(tag);
  endtask

  task automatic look(input logic ir, input logic [19:0] iv, input logic dr,
                      input logic [19:0] dv, input string tag);
    ilk_req = ir; ilk_vpn = iv; dlk_req = dr; dlk_vpn = dv; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int k = 0; k < 2*HALF; k++) begin
      m_v[k] = 0; m_tag[k] = 0; m_ppn[k] = 0; m_attr[k] = 0;
    end
    m_slot = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "slot", slot_rdata, 16'h0);
    chk("R1", "ihit", {ilk_hit, ilk_miss}, 2'b00);
    chk("R1", "dhit", {dlk_hit, dlk_miss}, 2'b00);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rvalid", ent_rvalid, 1'b0);
    look(1, 20'h0, 1, 20'h0, "R1");  // all entries invalid: both miss

    // R2: upper bits dropped
    set_slot(16'hFFC5, "R2");
    chk("R2", "slot_upper", slot_rdata, 16'h0005);

    // R3/R4/R5/R9: same tag in both halves, both ports together
    put(6'd3,  1, 20'h12345, 20'hABCDE, 3'b101, "R3");
    put(6'd35, 1, 20'h12345, 20'h11111, 3'b010, "R3");
    look(1, 20'h12345, 1, 20'h12345, "R9");
    chk("R4", "ippn", ilk_ppn, 20'hABCDE);
    chk("R5", "dppn", dlk_ppn, 20'h11111);

    // R5/R6: tag only in data half misses on instruction port
    put(6'd40, 1, 20'h55555, 20'h22222, 3'b001, "R5");
    look(1, 20'h55555, 1, 20'h55555, "R5");
    chk("R6", "imiss", {ilk_hit, ilk_miss, ilk_ppn}, {2'b01, 20'h0});

    // R8: lowest index wins; R7: invalidated entry no longer matches
    put(6'd10, 1, 20'h0BEEF, 20'h0000A, 3'b100, "R8");
    put(6'd7,  1, 20'h0BEEF, 20'h00007, 3'b011, "R8");
    look(1, 20'h0BEEF, 0, 20'h0, "R8");
    chk("R8", "ippn", ilk_ppn, 20'h00007);
    put(6'd7, 0, 20'h0BEEF, 20'h00007, 3'b011, "R7");
    look(1, 20'h0BEEF, 0, 20'h0, "R7");
    chk("R7", "ippn", ilk_ppn, 20'h0000A);

    // R11: slot write and entry write together use old index; lookup sees old contents
    set_slot(16'd12, "R11");
    slot_we = 1; slot_wdata = 16'd50;
    ent_we = 1; ent_wvalid = 1; ent_wtag = 20'h77777; ent_wppn = 20'h33333; ent_wattr = 3'b110;
    ilk_req = 1; ilk_vpn = 20'h77777;
    step("R11");
    chk("R11", "imiss_same_cycle", ilk_miss, 1'b1);
    look(1, 20'h77777, 1, 20'h77777, "R11");
    chk("R11", "ihit_after", {ilk_hit, ilk_ppn}, {1'b1, 20'h33333});
    chk("R11", "d_nohit", dlk_hit, 1'b0);

    // R10: idle ports
    look(0, 20'h12345, 0, 20'h12345, "R10");
    chk("R10", "idle", {ilk_hit, ilk_miss, dlk_hit, dlk_miss}, 4'b0);

    // Random traffic over a small tag pool
    for (int n = 0; n < 3000; n++) begin
      slot_we    = ($urandom % 4) == 0;
      slot_wdata = 16'($urandom);
      ent_we     = ($urandom % 3) == 0;
      ent_wvalid = ($urandom % 5) != 0;
      ent_wtag   = 20'($urandom % 12);
      ent_wppn   = 20'($urandom);
      ent_wattr  = 3'($urandom);
      ilk_req    = ($urandom % 4) != 0;
      ilk_vpn    = 20'($urandom % 12);
      dlk_req    = ($urandom % 4) != 0;
      dlk_vpn    = 20'($urandom % 12);
      step("R4/R5/R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule